// File: doc/BRIEF.md
# Hardware-Reset Status Qualifier

This block stands between the physical layer's status-transfer path and the host. It holds the local node's identity: node number, root flag and connection status. Each status strobe carries a fresh copy of these fields. The host reads them together with an identity-valid flag. Decoding of the serial status-transfer protocol happens upstream. This block sees only a one-cycle strobe with the fields already parallel.

After a hardware reset, the physical layer sends two status reports in the same bus-reset sequence. The first report is bogus: it claims root, node 0 and no connected peers. The second report is the real one. The block therefore discards the first strobe that follows a hardware reset and publishes only the second. A software-initiated reset or a reset received from the bus produces a single report, so no strobe is skipped after those. Every reset indication drops identity-valid until the next qualifying strobe has been latched.

In some cases the second report never comes. For that case a parameterised timeout promotes the held first report, so identity-valid is not stuck low forever.

Top module: `statusQualifier`

## Requirements
- R1: While `rstN` is low, and after it is released, `idValid`, `nodeId`, `isRoot` and `isConnected` are all 0 until a strobe is taken.
- R2: A high level on any of `hwResetEvt`, `swResetEvt` or `busResetEvt` at a clock edge drives `idValid` to 0 after that edge. The identity fields keep their previous values.
- R3: With no skip pending, a `statStrobe` at a clock edge copies `statNode`, `statRoot` and `statConnected` to `nodeId`, `isRoot` and `isConnected`, and sets `idValid` to 1, all after that same edge. Later strobes overwrite the fields. Without a strobe, the outputs hold.
- R4: The first `statStrobe` after a `hwResetEvt` leaves `idValid` at 0 and leaves all identity outputs unchanged.
- R5: The next `statStrobe` after the discarded one is latched and sets `idValid`, exactly as in R3.
- R6: After `swResetEvt` or `busResetEvt` alone, no strobe is skipped: the first strobe is latched as in R3.
- R7: Suppose no second strobe arrives within `WAIT_CYCLES` clock edges after the edge that discarded the first. Then, at the `WAIT_CYCLES`-th edge, the discarded fields are published and `idValid` becomes 1. Before that edge, `idValid` stays 0.
- R8: A strobe at the edge where the timeout would expire takes priority: its fields are published, not the held ones.
- R9: A reset indication at the same edge as a strobe wins, and the strobe is ignored. If `hwResetEvt` coincides with another reset indication, the skip of R4 still applies.
- R10: A `hwResetEvt` while a discarded report is being held restarts the sequence. The next strobe is discarded again, and the pending timeout is cancelled.
- R11: The node number is `NODE_W` bits wide, 6 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the block |
| hwResetEvt | input | 1 | One-cycle indication of a hardware reset of the physical layer |
| swResetEvt | input | 1 | One-cycle indication of a software-initiated bus reset |
| busResetEvt | input | 1 | One-cycle indication of a bus reset received over the bus |
| statStrobe | input | 1 | One-cycle strobe marking a decoded status transfer |
| statNode | input | NODE_W | Node number carried by the status transfer |
| statRoot | input | 1 | Root bit carried by the status transfer |
| statConnected | input | 1 | Connected bit carried by the status transfer |
| nodeId | output | NODE_W | Published node number |
| isRoot | output | 1 | Published root flag |
| isConnected | output | 1 | Published connection status |
| idValid | output | 1 | High when the published identity may be used |

## Verification
The assertions assume that the reset indications and the strobe are single-cycle pulses, sampled at the clock edge. They also assume that a reset indication and a strobe may coincide, with the reset taking priority. The random stimulus raises each indication on its own draw, so coincident events occur and are covered. The bench overrides `WAIT_CYCLES` to a small value, so that timeouts expire inside the random run. Strobes are frequent enough that second reports also arrive before expiry.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,   // no skip pending, strobes go straight out
    ST_SKIP = 2'd1,   // hardware reset seen, next strobe is discarded
    ST_HOLD = 2'd2    // first report held, awaiting second or timeout
  } qualState_e;

  typedef struct packed {
    logic loadLive;    // copy strobe fields to the outputs
    logic loadShadow;  // copy strobe fields to the holding register
    logic promote;     // copy holding register to the outputs
    logic setValid;
    logic clearValid;
  } qualCtrl_s;

endpackage

// File: rtl/statusQualCtrl.sv
module statusQualCtrl
  import sq_pkg::*;
#(
  parameter int WAIT_CYCLES = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hwResetEvt,
  input  logic      swResetEvt,
  input  logic      busResetEvt,
  input  logic      statStrobe,
  output qualCtrl_s ctl
);

  localparam int CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  qualState_e state, stateNext;
  logic [CNT_W-1:0] holdCnt, holdCntNext;
  logic anyReset;
  logic holdExpired;

  assign anyReset    = hwResetEvt | swResetEvt | busResetEvt;
  assign holdExpired = (holdCnt == CNT_LAST);

  always_comb begin
    ctl         = '0;
    stateNext   = state;
    holdCntNext = holdCnt;
    if (anyReset) begin
      ctl.clearValid = 1'b1;
      stateNext      = hwResetEvt ? ST_SKIP : ST_OPEN;
      holdCntNext    = '0;
    end else begin
      unique case (state)
        ST_OPEN: begin
          if (statStrobe) begin
            ctl.loadLive = 1'b1;
            ctl.setValid = 1'b1;
          end
        end
        ST_SKIP: begin
          if (statStrobe) begin
            ctl.loadShadow = 1'b1;
            stateNext      = ST_HOLD;
            holdCntNext    = '0;
          end
        end
        ST_HOLD: begin
          if (statStrobe) begin
            ctl.loadLive = 1'b1;
            ctl.setValid = 1'b1;
            stateNext    = ST_OPEN;
          end else if (holdExpired) begin
            ctl.promote  = 1'b1;
            ctl.setValid = 1'b1;
            stateNext    = ST_OPEN;
          end else begin
            holdCntNext = holdCnt + 1'b1;
          end
        end
        default: stateNext = ST_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OPEN;
      holdCnt <= '0;
    end else begin
      state   <= stateNext;
      holdCnt <= holdCntNext;
    end
  end

endmodule

// File: rtl/statusQualDatapath.sv
module statusQualDatapath
  import sq_pkg::*;
#(
  parameter int NODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  qualCtrl_s         ctl,
  input  logic [NODE_W-1:0] statNode,
  input  logic              statRoot,
  input  logic              statConnected,
  output logic [NODE_W-1:0] nodeId,
  output logic              isRoot,
  output logic              isConnected,
  output logic              idValid
);

  localparam int REC_W = NODE_W + 2;

  logic [REC_W-1:0] inRec, heldRec, liveRec;

  assign inRec = {statNode, statRoot, statConnected};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldRec <= '0;
      liveRec <= '0;
      idValid <= 1'b0;
    end else begin
      if (ctl.loadShadow) heldRec <= inRec;
      if (ctl.loadLive)     liveRec <= inRec;
      else if (ctl.promote) liveRec <= heldRec;
      if (ctl.clearValid)    idValid <= 1'b0;
      else if (ctl.setValid) idValid <= 1'b1;
    end
  end

  assign nodeId      = liveRec[REC_W-1:2];
  assign isRoot      = liveRec[1];
  assign isConnected = liveRec[0];

endmodule

// File: rtl/statusQualifier.sv
module statusQualifier
  import sq_pkg::*;
#(
  parameter int NODE_W      = 6,
  parameter int WAIT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwResetEvt,
  input  logic              swResetEvt,
  input  logic              busResetEvt,
  input  logic              statStrobe,
  input  logic [NODE_W-1:0] statNode,
  input  logic              statRoot,
  input  logic              statConnected,
  output logic [NODE_W-1:0] nodeId,
  output logic              isRoot,
  output logic              isConnected,
  output logic              idValid
);

  qualCtrl_s ctl;

  statusQualCtrl #(.WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hwResetEvt(hwResetEvt), .swResetEvt(swResetEvt), .busResetEvt(busResetEvt),
    .statStrobe(statStrobe), .ctl(ctl)
  );

  statusQualDatapath #(.NODE_W(NODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .statNode(statNode), .statRoot(statRoot), .statConnected(statConnected),
    .nodeId(nodeId), .isRoot(isRoot), .isConnected(isConnected), .idValid(idValid)
  );

endmodule

// File: rtl/statusQualChecker.sv
module statusQualChecker #(
  parameter int NODE_W      = 6,
  parameter int WAIT_CYCLES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              hwResetEvt,
  input logic              swResetEvt,
  input logic              busResetEvt,
  input logic              statStrobe,
  input logic [NODE_W-1:0] statNode,
  input logic              statRoot,
  input logic              statConnected,
  input logic [NODE_W-1:0] nodeId,
  input logic              isRoot,
  input logic              isConnected,
  input logic              idValid
);

  localparam int CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  logic anyRst;
  logic skipFlag, holdFlag;
  logic [CNT_W-1:0] waitCnt;

  assign anyRst = hwResetEvt | swResetEvt | busResetEvt;

  // Observer of the skip window, built from the port-level protocol
  always_ff @(posedge clk) begin
    if (!rstN) begin
      skipFlag <= 1'b0;
      holdFlag <= 1'b0;
      waitCnt  <= '0;
    end else if (anyRst) begin
      skipFlag <= hwResetEvt;
      holdFlag <= 1'b0;
      waitCnt  <= '0;
    end else if (skipFlag && statStrobe) begin
      skipFlag <= 1'b0;
      holdFlag <= 1'b1;
      waitCnt  <= '0;
    end else if (holdFlag) begin
      if (statStrobe || waitCnt == CNT_LAST) holdFlag <= 1'b0;
      else waitCnt <= waitCnt + 1'b1;
    end
  end

  AST_RESET_DROPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    anyRst |=> !idValid); // R2

  AST_FIRST_DISCARDED: assert property (@(posedge clk) disable iff (!rstN)
    (skipFlag && statStrobe && !anyRst) |=>
      (!idValid && $stable(nodeId) && $stable(isRoot) && $stable(isConnected))); // R4

  AST_LIVE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (!skipFlag && !holdFlag && statStrobe && !anyRst) |=>
      (idValid && nodeId == $past(statNode) && isRoot == $past(statRoot)
       && isConnected == $past(statConnected))); // R3

  AST_SECOND_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlag && statStrobe && !anyRst) |=>
      (idValid && nodeId == $past(statNode) && isRoot == $past(statRoot))); // R5

  AST_TIMEOUT_PROMOTE: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlag && !statStrobe && !anyRst && waitCnt == CNT_LAST) |=> idValid); // R7

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlag && !statStrobe && !anyRst && waitCnt != CNT_LAST) |=> !idValid); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!holdFlag && !statStrobe && !anyRst) |=>
      ($stable(nodeId) && $stable(isRoot) && $stable(isConnected) && $stable(idValid))); // R3

  AST_RESET_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    anyRst |=> ($stable(nodeId) && $stable(isRoot) && $stable(isConnected))); // R9

endmodule

bind statusQualifier statusQualChecker #(.NODE_W(NODE_W), .WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN),
  .hwResetEvt(hwResetEvt), .swResetEvt(swResetEvt), .busResetEvt(busResetEvt),
  .statStrobe(statStrobe), .statNode(statNode), .statRoot(statRoot),
  .statConnected(statConnected), .nodeId(nodeId), .isRoot(isRoot),
  .isConnected(isConnected), .idValid(idValid)
);

// File: tb/statusQualifier_test.sv
module statusQualifier_test;

  localparam int CLK_PERIOD = 10;
  localparam int NODE_W     = 6;
  localparam int WAITC      = 8;
  localparam int SEED       = 1234;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwResetEvt = 0, swResetEvt = 0, busResetEvt = 0, statStrobe = 0;
  logic [NODE_W-1:0] statNode = '0;
  logic statRoot = 0, statConnected = 0;
  logic [NODE_W-1:0] nodeId;
  logic isRoot, isConnected, idValid;

  int checks = 0;
  int errors = 0;

  // reference model state
  int mState = 0;   // 0 open, 1 skip, 2 hold
  int mCnt   = 0;
  logic [NODE_W-1:0] eNode = '0, hNode = '0;
  logic eRoot = 0, eConn = 0, eValid = 0, hRoot = 0, hConn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statusQualifier #(.NODE_W(NODE_W), .WAIT_CYCLES(WAITC)) uut (
    .clk(clk), .rstN(rstN),
    .hwResetEvt(hwResetEvt), .swResetEvt(swResetEvt), .busResetEvt(busResetEvt),
    .statStrobe(statStrobe), .statNode(statNode), .statRoot(statRoot),
    .statConnected(statConnected), .nodeId(nodeId), .isRoot(isRoot),
    .isConnected(isConnected), .idValid(idValid)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  function automatic logic [NODE_W+2:0] packOut(logic v, logic [NODE_W-1:0] n, logic r, logic c);
    return {v, n, r, c};
  endfunction

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkModel(string tag);
    checkVal(tag, 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(eValid, eNode, eRoot, eConn)));
  endtask

  // next expected outputs from the current inputs, per R2..R10
  task automatic modelStep();
    if (hwResetEvt || swResetEvt || busResetEvt) begin
      eValid = 0;
      mState = hwResetEvt ? 1 : 0;
      mCnt   = 0;
    end else if (mState == 0) begin
      if (statStrobe) begin
        eNode = statNode; eRoot = statRoot; eConn = statConnected; eValid = 1;
      end
    end else if (mState == 1) begin
      if (statStrobe) begin
        hNode = statNode; hRoot = statRoot; hConn = statConnected;
        mState = 2; mCnt = 0;
      end
    end else begin
      if (statStrobe) begin
        eNode = statNode; eRoot = statRoot; eConn = statConnected; eValid = 1; mState = 0;
      end else if (mCnt == WAITC - 1) begin
        eNode = hNode; eRoot = hRoot; eConn = hConn; eValid = 1; mState = 0;
      end else mCnt++;
    end
  endtask

  task automatic step(logic h, logic s, logic b, logic st,
                      logic [NODE_W-1:0] n, logic r, logic c);
    hwResetEvt = h; swResetEvt = s; busResetEvt = b;
    statStrobe = st; statNode = n; statRoot = r; statConnected = c;
    modelStep();
    @(negedge clk);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, '0, 0, 0);
  endtask

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    checkVal("R1 valid in reset", 32'(idValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 outputs after reset", 32'(packOut(idValid, nodeId, isRoot, isConnected)), 0);

    // R3: direct latch, then overwrite
    step(0, 0, 0, 1, 6'd17, 0, 1);
    checkVal("R3 first latch", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(1, 6'd17, 0, 1)));
    step(0, 0, 0, 1, 6'd63, 1, 1);
    checkVal("R11 full-width node", 32'(nodeId), 32'd63);
    idle(3);
    checkModel("R3 hold without strobe");

    // R2 + R4 + R5: hardware reset, bogus first report, then real one
    step(1, 0, 0, 0, '0, 0, 0);
    checkVal("R2 valid dropped, fields kept", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(0, 6'd63, 1, 1)));
    step(0, 0, 0, 1, 6'd0, 1, 0);
    checkVal("R4 first report discarded", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(0, 6'd63, 1, 1)));
    idle(2);
    step(0, 0, 0, 1, 6'd9, 0, 1);
    checkVal("R5 second report taken", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(1, 6'd9, 0, 1)));

    // R6: software and bus resets have no skip
    step(0, 1, 0, 0, '0, 0, 0);
    step(0, 0, 0, 1, 6'd22, 1, 1);
    checkVal("R6 soft reset no skip", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(1, 6'd22, 1, 1)));
    step(0, 0, 1, 0, '0, 0, 0);
    step(0, 0, 0, 1, 6'd5, 0, 0);
    checkVal("R6 bus reset no skip", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(1, 6'd5, 0, 0)));

    // R7: timeout promotes the held report at the WAITC-th edge
    step(1, 0, 0, 0, '0, 0, 0);
    step(0, 0, 0, 1, 6'd33, 1, 0);
    idle(WAITC - 1);
    checkVal("R7 still invalid before expiry", 32'(idValid), 0);
    idle(1);
    checkVal("R7 promoted on expiry", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(1, 6'd33, 1, 0)));

    // R8: strobe on the expiry edge wins
    step(1, 0, 0, 0, '0, 0, 0);
    step(0, 0, 0, 1, 6'd40, 1, 1);
    idle(WAITC - 1);
    step(0, 0, 0, 1, 6'd41, 0, 0);
    checkVal("R8 strobe beats timeout", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(1, 6'd41, 0, 0)));

    // R9: reset and strobe coincide; hw with sw still skips
    step(1, 1, 0, 1, 6'd12, 1, 1);
    checkVal("R9 strobe ignored under reset", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(0, 6'd41, 0, 0)));
    step(0, 0, 0, 1, 6'd13, 0, 1);
    checkVal("R9 hw+sw keeps skip", 32'(idValid), 0);

    // R10: hw reset during hold restarts the skip and cancels the timeout
    idle(2);
    step(1, 0, 0, 0, '0, 0, 0);
    step(0, 0, 0, 1, 6'd14, 1, 0);
    checkVal("R10 re-skip after restart", 32'(idValid), 0);
    idle(WAITC);
    checkVal("R10 new held report promoted", 32'(packOut(idValid, nodeId, isRoot, isConnected)),
             32'(packOut(1, 6'd14, 1, 0)));

    // Random mix against the reference model (R2..R10)
    for (int i = 0; i < 3000; i++) begin
      logic h, s, b, st;
      h  = ($urandom_range(99) < 3);
      s  = ($urandom_range(99) < 2);
      b  = ($urandom_range(99) < 2);
      st = ($urandom_range(99) < 12);
      step(h, s, b, st, NODE_W'($urandom), 1'($urandom), 1'($urandom));
      checkModel("R9 random sequence vs model");
    end

    report();
  end

endmodule